// File: doc/BRIEF.md
# Fast PWM Timer With Two Compare Channels

This block is a 16-bit up-counter with two compare channels, each of which can drive an output pin. In normal mode the counter runs through the full 16-bit range, and a connected pin toggles whenever the count equals that channel's compare value. In the 10-bit fast PWM mode the counter runs from 0 to 1023 and then restarts. Each connected pin then gives a pulse-width-modulated level whose duty cycle comes from its compare value. A channel can be set up as a non-inverting output or an inverting output. It can also be left disconnected, so that ordinary port logic keeps control of the pin.

Software configures the block through one register-write port. Address 0 holds the control word, which sets the counting mode, each channel's output mode and the clock divider. Addresses 1 and 2 hold the compare values. Address 3 loads the counter.

While the 10-bit mode is active, a compare value is cut to ten bits at the moment it is written, and the cut value is what gets stored. Changing the mode later does not rewrite the value in either direction. In PWM mode, a new compare value waits until the counter wraps before it takes effect. The corner values of 0 and 1023 give a one-count spike and a steady level.

Top module: `fast_pwm_timer`

## Requirements
- R1: After reset, both pins and both drive flags are low, the count is 0, the mode is normal and the clock divider is stopped, so the count stays at 0.
- R2: In fast PWM mode, on each timer tick the count advances by one from 0 up to 0x03FF, and the tick after 0x03FF returns it to 0.
- R3: In normal mode, on each timer tick the count advances by one through the full 16-bit range, and 0xFFFF is followed by 0.
- R4: Output mode codes: 2'b10 is non-inverting and 2'b11 is inverting, and both raise the drive flag. The codes 2'b00 and 2'b01 leave the pin disconnected: the drive flag is low and the pin is held low.
- R5: The clock-select field gives the timer tick rate: 1 ticks on every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024. The codes 0, 6 and 7 stop the counter.
- R6: In fast PWM mode, a non-inverting pin is high exactly while count <= compare. A compare value of 1023 therefore gives a steady high, and 0 gives a high spike lasting one count in every 1024.
- R7: In fast PWM mode, an inverting pin is the complement of the R6 level. A compare value of 1023 gives a steady low with no pulse at the end of the period, and 0 gives a low spike lasting one count in every 1024.
- R8: In fast PWM mode, a compare write stores data & 0x03FF. For example, 0x0400 is stored as 0 and 0xFFFF is stored as 0x03FF.
- R9: In fast PWM mode, a newly written compare value first acts in the period that starts when the count wraps from 0x03FF to 0. Until then the old value stays in force.
- R10: In normal mode, a compare write stores the full value and takes effect at once. A value that was masked in fast PWM mode stays masked after a return to normal mode. A value written in normal mode is not re-masked when fast PWM mode is entered.
- R11: In normal mode, a connected pin toggles on a tick at which the count equals its compare value, and it holds its level otherwise. The toggle first shows at count = compare + 1.
- R12: Register map: address 0 is the control word, with the mode in bits [3:0], channel A output mode in [5:4], channel B output mode in [7:6] and clock select in [10:8]. Address 1 is compare A, address 2 is compare B, and address 3 loads the count, cut to 10 bits in fast PWM mode. Mode code 4'b0111 is fast PWM, and every other mode code behaves as normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 compare A, 2 compare B, 3 count) |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Channel A pin level |
| pwm_b | output | 1 | Channel B pin level |
| drive_a | output | 1 | High when the timer owns pin A |
| drive_b | output | 1 | High when the timer owns pin B |
| timer_count | output | 16 | Current counter value |

## Verification
A wrong stored compare value shows within one PWM period as a pin edge at the wrong count. It also shows when a mode switch moves a normal-mode toggle away from compare + 1. A compare value swapped in before the wrap shows as a mismatch in the remainder of the current period. A wrong divider tap shows as the wrong spacing between count steps within a few thousand clocks. A missing wrap shows at the first pass of 0x03FF.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    localparam logic [3:0] WAVE_FAST = 4'b0111;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CMP_A = 2'd1;
    localparam logic [1:0] ADDR_CMP_B = 2'd2;
    localparam logic [1:0] ADDR_COUNT = 2'd3;

    localparam int PRE_W = 10;

    typedef enum logic [1:0] {
        COM_OFF    = 2'b00,
        COM_RSVD   = 2'b01,
        COM_NONINV = 2'b10,
        COM_INV    = 2'b11
    } com_e;

    typedef struct packed {
        logic [2:0] clk_sel;
        com_e       com_b;
        com_e       com_a;
        logic [3:0] wave;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // log2 of the divide ratio; -1 means stopped
    function automatic int div_log(input logic [2:0] sel);
        case (sel)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/fpt_prescaler.sv
module fpt_prescaler #(
    parameter int PRE_W = fpt_pkg::PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    int               shift;
    logic [PRE_W-1:0] tap_mask;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
        shift    = fpt_pkg::div_log(sel);
        tap_mask = PRE_W'((1 << ((shift < 0) ? 0 : shift)) - 1);
        if (shift < 0)
            tick = 1'b0;
        else
            tick = ((st_q.pre & tap_mask) == tap_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // divided rates never tick on two neighbouring clocks
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel inside {3'd2, 3'd3, 3'd4, 3'd5}) && $stable(sel) && tick |=> !tick); // R5

endmodule

// File: rtl/fpt_channel.sv
module fpt_channel #(
    parameter int                CNT_W = 16,
    parameter logic [CNT_W-1:0]  TOP   = 16'h03FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wr_data,
    input  fpt_pkg::com_e    com,
    output logic             pin,
    output logic             drive
);
    import fpt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] act;
        logic             lvl;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   connected;
    logic   inverting;

    assign connected = (com == COM_NONINV) || (com == COM_INV);
    assign inverting = (com == COM_INV);

    always_comb begin
        st_d = st_q;
        if (wrap)
            st_d.act = st_q.hold;
        if (wr_cmp) begin
            if (fast) begin
                st_d.hold = wr_data & TOP;
            end else begin
                st_d.hold = wr_data;
                st_d.act  = wr_data;
            end
        end
        if (!connected)
            st_d.lvl = 1'b0;
        else if (fast)
            st_d.lvl = (cnt_d <= st_d.act) ^ inverting;
        else if (tick && (cnt_q == st_q.act))
            st_d.lvl = ~st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin   = st_q.lvl;
    assign drive = connected;

    AST_MASKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        fast && wr_cmp |=> ((st_q.hold & ~TOP) == '0)); // R8

    AST_DISC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !connected && $past(!connected) |-> !pin); // R4

    AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fast && $past(!fast) && connected && $past(connected)
        && !$past(tick && (cnt_q == st_q.act)) |-> $stable(pin)); // R11

    AST_ACT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        fast && $past(fast) && !$past(wrap) |-> $stable(st_q.act)); // R9

endmodule

// File: rtl/fast_pwm_timer.sv
module fast_pwm_timer #(
    parameter int CNT_W    = 16,
    parameter int PWM_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             drive_a,
    output logic             drive_b,
    output logic [CNT_W-1:0] timer_count
);
    import fpt_pkg::*;

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t TOP    = cnt_t'((1 << PWM_BITS) - 1);
    localparam int   N_CHAN = 2;

    typedef struct packed {
        ctrl_t ctrl;
        cnt_t  cnt;
    } tmr_st_t;

    tmr_st_t     st_d, st_q;
    logic        tick;
    logic        fast;
    logic        wrap;
    logic        wr_ctrl;
    logic        wr_cnt;
    logic [N_CHAN-1:0] wr_cmp;
    com_e        com_sel [N_CHAN];
    logic [N_CHAN-1:0] pin_v;
    logic [N_CHAN-1:0] drv_v;

    assign fast      = (st_q.ctrl.wave == WAVE_FAST);
    assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_cnt    = wr_en && (wr_addr == ADDR_COUNT);
    assign wr_cmp[0] = wr_en && (wr_addr == ADDR_CMP_A);
    assign wr_cmp[1] = wr_en && (wr_addr == ADDR_CMP_B);
    assign com_sel[0] = st_q.ctrl.com_a;
    assign com_sel[1] = st_q.ctrl.com_b;
    assign wrap      = fast && tick && (st_q.cnt >= TOP);

    fpt_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (st_q.ctrl.clk_sel),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        if (wr_cnt)
            st_d.cnt = fast ? (wr_data & TOP) : wr_data;
        else if (tick) begin
            if (fast && (st_q.cnt >= TOP))
                st_d.cnt = '0;
            else
                st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        fpt_channel #(.CNT_W(CNT_W), .TOP(TOP)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .fast    (fast),
            .tick    (tick),
            .wrap    (wrap),
            .cnt_q   (st_q.cnt),
            .cnt_d   (st_d.cnt),
            .wr_cmp  (wr_cmp[g]),
            .wr_data (wr_data),
            .com     (com_sel[g]),
            .pin     (pin_v[g]),
            .drive   (drv_v[g])
        );
    end

    assign pwm_a       = pin_v[0];
    assign pwm_b       = pin_v[1];
    assign drive_a     = drv_v[0];
    assign drive_b     = drv_v[1];
    assign timer_count = st_q.cnt;

    AST_FAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        fast && tick && (st_q.cnt == TOP) && !wr_cnt |=> (st_q.cnt == '0)); // R2

    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !fast && tick && !wr_cnt && !wr_ctrl
        |=> (st_q.cnt == cnt_t'($past(st_q.cnt) + 1'b1))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !wr_cnt |=> $stable(st_q.cnt)); // R5

endmodule

// File: tb/fast_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module fast_pwm_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        pwm_a, pwm_b, drive_a, drive_b;
    logic [15:0] timer_count;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fast_pwm_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_a       (pwm_a),
        .pwm_b       (pwm_b),
        .drive_a     (drive_a),
        .drive_b     (drive_b),
        .timer_count (timer_count)
    );

    localparam logic [15:0] TOP = 16'h03FF;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl_word(input logic [3:0] wave, input logic [1:0] ca,
                                              input logic [1:0] cb, input logic [2:0] cs);
        return {5'b0, cs, cb, ca, wave};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_top(input string req);
        bit found = 1'b0;
        for (int i = 0; i < 70000; i++) begin
            if (timer_count == TOP) begin found = 1'b1; break; end
            @(negedge clk);
        end
        @(negedge clk);
        check(found && timer_count == 16'h0, req, "wrap after top", timer_count, 0);
    endtask

    // one full period starting at count 0: A non-inverting, B inverting
    task automatic run_period(input logic [15:0] ea, input logic [15:0] eb, input bit chk_b,
                              input string req_a, input string req_b);
        int bad_a = 0, bad_b = 0;
        logic fa_act = 0, fa_exp = 0, fb_act = 0, fb_exp = 0;
        for (int i = 0; i < 1024; i++) begin
            logic xa, xb;
            xa = (timer_count <= ea);
            xb = !(timer_count <= eb);
            if (pwm_a !== xa) begin
                if (bad_a == 0) begin fa_act = pwm_a; fa_exp = xa; end
                bad_a++;
            end
            if (chk_b && pwm_b !== xb) begin
                if (bad_b == 0) begin fb_act = pwm_b; fb_exp = xb; end
                bad_b++;
            end
            @(negedge clk);
        end
        check(bad_a == 0, req_a, $sformatf("pin A cmp %0h", ea), fa_act, fa_exp);
        if (chk_b)
            check(bad_b == 0, req_b, $sformatf("pin B cmp %0h", eb), fb_act, fb_exp);
    endtask

    // waits for the first toggle of a pin and reports the count at that moment
    task automatic watch_toggle(input bit which_b, input logic [15:0] exp_cnt, input string req);
        logic prev, cur;
        bit   got = 1'b0;
        logic [15:0] seen = 16'h0;
        prev = which_b ? pwm_b : pwm_a;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            cur = which_b ? pwm_b : pwm_a;
            if (cur !== prev) begin got = 1'b1; seen = timer_count; break; end
        end
        check(got && seen == exp_cnt, req, "toggle count", seen, exp_cnt);
    endtask

    task automatic meas_div(input logic [2:0] cs, input int exp);
        logic [15:0] prev;
        int n = 0;
        wr(2'd0, ctrl_word(4'b0000, 2'b00, 2'b00, cs));
        prev = timer_count;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (timer_count != prev) break;
        end
        prev = timer_count;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            n++;
            if (timer_count != prev) break;
        end
        check(n == exp, "R5", $sformatf("step spacing sel %0d", cs), n, exp);
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] vals [10];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0064, 16'h01FF,
                 16'h03FE, 16'h03FF, 16'h0400, 16'h07FF, 16'hFFFF};
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pwm_a == 0 && pwm_b == 0, "R1", "pins after reset", {pwm_a, pwm_b}, 0);
        check(drive_a == 0 && drive_b == 0, "R1", "drives after reset", {drive_a, drive_b}, 0);
        repeat (20) @(negedge clk);
        check(timer_count == 0, "R1", "count stays 0", timer_count, 0);

        // R3 normal full-range wrap
        wr(2'd0, ctrl_word(4'b0000, 2'b00, 2'b00, 3'd1));
        wr(2'd3, 16'hFFFE);
        check(timer_count == 16'hFFFE, "R12", "count load", timer_count, 16'hFFFE);
        @(negedge clk);
        check(timer_count == 16'hFFFF, "R3", "step to FFFF", timer_count, 16'hFFFF);
        @(negedge clk);
        check(timer_count == 16'h0000, "R3", "wrap to 0", timer_count, 0);

        // R12 other mode code acts as normal
        wr(2'd0, ctrl_word(4'b0101, 2'b00, 2'b00, 3'd1));
        wr(2'd3, 16'h03FE);
        repeat (3) @(negedge clk);
        check(timer_count == 16'h0401, "R12", "code 0101 counts past top", timer_count, 16'h0401);

        // R5 divider
        meas_div(3'd2, 8);
        meas_div(3'd3, 64);
        meas_div(3'd4, 256);
        meas_div(3'd5, 1024);
        for (int c = 0; c < 8; c += 6) begin
            wr(2'd0, ctrl_word(4'b0000, 2'b00, 2'b00, 3'(c)));
            v = timer_count;
            repeat (50) @(negedge clk);
            check(timer_count == v, "R5", $sformatf("stopped sel %0d", c), timer_count, v);
        end

        // fast PWM, A non-inverting, B inverting
        wr(2'd0, ctrl_word(4'b0111, 2'b10, 2'b11, 3'd1));
        check(drive_a == 1 && drive_b == 1, "R4", "drives connected", {drive_a, drive_b}, 3);
        wr(2'd3, 16'h1405);
        check(timer_count == 16'h0005, "R12", "count load masked", timer_count, 5);
        foreach (vals[k]) begin
            wr(2'd1, vals[k]);
            wr(2'd2, vals[k]);
            sync_top("R2");
            // R6 R7 R8: effective compare is the masked value
            run_period(vals[k] & TOP, vals[k] & TOP, 1'b1, "R6", "R7");
        end

        // R9 double buffering
        wr(2'd1, 16'd100);
        wr(2'd2, 16'd100);
        sync_top("R2");
        for (int i = 0; i < 2000; i++) begin
            if (timer_count == 16'd200) break;
            @(negedge clk);
        end
        wr(2'd1, 16'd500);
        wr(2'd2, 16'd500);
        begin
            int bad = 0;
            for (int i = 0; i < 1024; i++) begin
                if (pwm_a !== (timer_count <= 16'd100)) bad++;
                if (timer_count == TOP) break;
                @(negedge clk);
            end
            check(bad == 0, "R9", "old compare kept until wrap", bad, 0);
        end
        @(negedge clk);
        run_period(16'd500, 16'd500, 1'b1, "R9", "R9");

        // R4 disconnected codes
        wr(2'd0, ctrl_word(4'b0111, 2'b00, 2'b01, 3'd1));
        check(drive_a == 0 && drive_b == 0, "R4", "drives off", {drive_a, drive_b}, 0);
        begin
            int hi = 0;
            for (int i = 0; i < 1100; i++) begin
                @(negedge clk);
                if (pwm_a || pwm_b) hi++;
            end
            check(hi == 0, "R4", "disconnected pins low", hi, 0);
        end

        // R10 masked value survives return to normal; R11 toggle point
        wr(2'd0, ctrl_word(4'b0111, 2'b10, 2'b11, 3'd1));
        wr(2'd2, 16'h0400);
        sync_top("R2");
        wr(2'd0, ctrl_word(4'b0000, 2'b10, 2'b11, 3'd1));
        wr(2'd3, 16'hFFFD);
        watch_toggle(1'b1, 16'h0001, "R10");

        // R10 normal write unmasked and immediate; R11
        wr(2'd1, 16'h0400);
        wr(2'd3, 16'h03F0);
        watch_toggle(1'b0, 16'h0401, "R11");

        // R10 value written in normal mode not re-masked on entering fast
        wr(2'd1, 16'h0500);
        wr(2'd0, ctrl_word(4'b0111, 2'b10, 2'b11, 3'd1));
        sync_top("R2");
        run_period(16'h0500, 16'h0, 1'b0, "R10", "R10");

        done = 1'b1;
        report();
        $finish;
    end

endmodule